// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns characters into asynchronous NRZ frames on a single output line. The line rests high. Each frame has one low start bit, then 1 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The frame format is chosen at run time through plain control pins. An external bit tick sets the bit period: the line moves to its next bit only in a cycle where `bit_tick` is high.

Characters enter through a valid/ready stream port. Behind that port sits one holding register, and behind it a shift register. The producer can therefore hand over the next character while the current one is still shifting out. A character is accepted in any cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the holding register is occupied and any `in_valid` is back-pressured: the data is neither stored nor allowed to disturb the frame on the line. `in_ready` doubles as the buffer-ready status, and `shift_empty` reports that the shifter has finished. An interrupt output, masked by `irq_en`, requests the next character.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `tx_line` is 1, `in_ready` is 1, `shift_empty` is 1 and `irq` is 0 while `irq_en` is 0.
- R2: A frame starts with exactly one low bit, followed by `cfg_len_m1`+1 data bits sent least significant bit first. The field `cfg_len_m1` holds the data length minus one, so 0 means 1 bit and 7 means 8 bits.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. It equals the XOR of the configured data bits when `cfg_par_odd` is 0 (even) and the inverse of that XOR when `cfg_par_odd` is 1 (odd). Data bits above the configured length have no influence. When `cfg_par_en` is 0, no parity bit is sent.
- R4: The frame ends with one high stop bit, or two when `cfg_two_stop` is 1.
- R5: A character is stored when `in_valid` and `in_ready` are both high, and `in_ready` is low in the next cycle. A write presented while `in_ready` is low is ignored: neither the held character nor the frame in progress changes.
- R6: The held character moves into the shifter on a bit tick. `in_ready` returns to 1 in the cycle after that tick, and it rises at no other time.
- R7: If a character is held when the last stop bit ends, the next start bit begins on that same tick, so there is no idle bit between frames.
- R8: `shift_empty` is 0 from the tick that loads the shifter until the tick that ends the last stop bit. While `shift_empty` is 1, the line is high.
- R9: While `tx_en` is 0, no new frame starts. A frame already in progress runs to its end.
- R10: The frame format is captured when the shifter loads. Changing the format pins during a frame does not alter that frame.
- R11: `irq` is 1 exactly when `irq_en` is 1 and `in_ready` is 1.
- R12: `tx_line` changes only in the cycle after a cycle in which `bit_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Allows new frames to start |
| bit_tick | input | 1 | One-cycle pulse for each bit period |
| cfg_len_m1 | input | 3 | Data length minus one |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| irq_en | input | 1 | Interrupt mask |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Holding register free (buffer-ready flag) |
| tx_line | output | 1 | Serial output, idles high |
| shift_empty | output | 1 | Shifter idle |
| irq | output | 1 | Masked request for the next character |

## Verification
The bench aims at the edges of the frame format. It sends 1-bit characters and 7-bit characters whose unused top bit is set; a design that took parity over all eight bits would send the wrong parity bit. It also sends back-to-back characters, where a late handoff would insert an idle high bit between the frames. A third character written while the holding register is full must not replace the one waiting. Two tests change the controls during a frame. One edits the format pins, which catches a shifter that reads the live pins instead of a captured copy. The other drops `tx_en` mid-frame, which catches a design that cuts the frame short or starts a frame while disabled.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Phase of the frame currently driven on the line.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP1 = 3'd4,
    PH_STOP2 = 3'd5
  } tx_phase_e;
endpackage

// File: rtl/tx_hold_buf.sv
// Single-entry holding register sitting in front of the shifter.
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  // A write and a take are mutually exclusive: a write needs the buffer
  // empty, a take needs it full.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready  = !full_q;
  assign hold_full = full_q;
  assign hold_data = data_q;
endmodule

// File: rtl/tx_parity_calc.sv
// Parity over only the low (len_m1+1) bits of the character.
module tx_parity_calc #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              odd,
  output logic              par_bit
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mask[i] = (i <= int'(len_m1));
    end
  end

  assign par_bit = (^(data & mask)) ^ odd;
endmodule

// File: rtl/tx_frame_shifter.sv
// Shift register plus frame sequencer; captures the format at load.
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_par_en,
  input  logic              cfg_two_stop,
  input  logic              par_in,
  output logic              take,
  output logic              tx_line,
  output logic              shift_empty
);
  tx_phase_e         phase_q;
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              pe_q;
  logic              par_q;
  logic              two_q;
  logic              line_q;
  logic              frame_end;
  logic              can_load;

  assign frame_end = (phase_q == PH_STOP2) || ((phase_q == PH_STOP1) && !two_q);
  assign can_load  = tx_en && hold_full && ((phase_q == PH_IDLE) || frame_end);
  assign take      = bit_tick && can_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      pe_q    <= 1'b0;
      par_q   <= 1'b0;
      two_q   <= 1'b0;
      line_q  <= 1'b1;
    end else if (bit_tick) begin
      if (can_load) begin
        phase_q <= PH_START;
        line_q  <= 1'b0;
        sh_q    <= hold_data;
        len_q   <= cfg_len_m1;
        pe_q    <= cfg_par_en;
        par_q   <= par_in;
        two_q   <= cfg_two_stop;
        cnt_q   <= '0;
      end else begin
        unique case (phase_q)
          PH_START: begin
            phase_q <= PH_DATA;
            line_q  <= sh_q[0];
            sh_q    <= {1'b0, sh_q[DATA_W-1:1]};
            cnt_q   <= '0;
          end
          PH_DATA: begin
            if (cnt_q == len_q) begin
              if (pe_q) begin
                phase_q <= PH_PAR;
                line_q  <= par_q;
              end else begin
                phase_q <= PH_STOP1;
                line_q  <= 1'b1;
              end
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              line_q <= sh_q[0];
              sh_q   <= {1'b0, sh_q[DATA_W-1:1]};
            end
          end
          PH_PAR: begin
            phase_q <= PH_STOP1;
            line_q  <= 1'b1;
          end
          PH_STOP1: begin
            phase_q <= two_q ? PH_STOP2 : PH_IDLE;
            line_q  <= 1'b1;
          end
          PH_STOP2: begin
            phase_q <= PH_IDLE;
            line_q  <= 1'b1;
          end
          default: begin
            phase_q <= PH_IDLE;
            line_q  <= 1'b1;
          end
        endcase
      end
    end
  end

  assign tx_line     = line_q;
  assign shift_empty = (phase_q == PH_IDLE);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DATA_W = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              irq_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_line,
  output logic              shift_empty,
  output logic              irq
);
  logic              take;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              par_bit;

  tx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  tx_parity_calc #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_par (
    .data    (hold_data),
    .len_m1  (cfg_len_m1),
    .odd     (cfg_par_odd),
    .par_bit (par_bit)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .tx_en        (tx_en),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .cfg_len_m1   (cfg_len_m1),
    .cfg_par_en   (cfg_par_en),
    .cfg_two_stop (cfg_two_stop),
    .par_in       (par_bit),
    .take         (take),
    .tx_line      (tx_line),
    .shift_empty  (shift_empty)
  );

  assign irq = irq_en && in_ready;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic bit_tick,
  input logic in_valid,
  input logic in_ready,
  input logic tx_line,
  input logic shift_empty,
  input logic irq
);
  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(bit_tick));

  // R12
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_line));

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty |-> tx_line);

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty && !tx_en |=> shift_empty);

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !irq);
endmodule

bind uart_tx_dbuf uart_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_en       (tx_en),
  .bit_tick    (bit_tick),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .tx_line     (tx_line),
  .shift_empty (shift_empty),
  .irq         (irq)
);

// File: tb/tb_uart_tx_dbuf.sv
module tb_uart_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       bit_tick = 1'b0;
  logic [2:0] cfg_len_m1 = 3'd7;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       irq_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, tx_line, shift_empty, irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_tx_dbuf dut (.*);

  // Fields: len_m1[13:11], par_en[10], par_odd[9], two_stop[8], data[7:0]
  localparam logic [13:0] VEC [0:7] = '{
    {3'd7, 1'b0, 1'b0, 1'b0, 8'h55},
    {3'd7, 1'b1, 1'b0, 1'b0, 8'hA7},
    {3'd7, 1'b1, 1'b1, 1'b1, 8'hA7},
    {3'd4, 1'b1, 1'b0, 1'b0, 8'hF3},
    {3'd0, 1'b1, 1'b1, 1'b0, 8'h01},
    {3'd0, 1'b0, 1'b0, 1'b1, 8'hFE},
    {3'd6, 1'b1, 1'b1, 1'b0, 8'h80},
    {3'd3, 1'b0, 1'b0, 1'b1, 8'h0C}
  };

  task automatic check(input bit ok, input string req, input logic [11:0] got,
                       input logic [11:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk) begin in_valid = 1'b1; in_data = d; end
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic set_fmt(input logic [2:0] l, input logic pe, input logic po,
                         input logic ts);
    cfg_len_m1 = l; cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
  endtask

  // Expected line bits of one whole frame, bit 0 first.
  task automatic build_frame(input logic [2:0] l, input logic pe, input logic po,
                             input logic ts, input logic [7:0] d,
                             output logic [11:0] e, output int n);
    logic p;
    e = '0; n = 0; p = po;
    e[n++] = 1'b0;
    for (int i = 0; i <= int'(l); i++) begin
      e[n++] = d[i];
      p ^= d[i];
    end
    if (pe) e[n++] = p;
    e[n++] = 1'b1;
    if (ts) e[n++] = 1'b1;
  endtask

  task automatic capture(input int first, input int n, inout logic [11:0] g);
    for (int i = first; i < n; i++) begin
      tick();
      g[i] = tx_line;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] e, g;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_line && in_ready && shift_empty && !irq, "R1 reset",
          {8'h0, tx_line, in_ready, shift_empty, irq}, 12'b1110);

    // Table of formats: R2 R3 R4 R8
    for (int v = 0; v < 8; v++) begin
      set_fmt(VEC[v][13:11], VEC[v][10], VEC[v][9], VEC[v][8]);
      build_frame(VEC[v][13:11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0], e, n);
      write_char(VEC[v][7:0]);
      check(!in_ready, "R5 ready low after write", {11'h0, in_ready}, 12'h0);
      g = '0;
      capture(0, 1, g);
      check(!shift_empty && in_ready, "R6 R8 load on tick",
            {10'h0, shift_empty, in_ready}, 12'b01);
      capture(1, n, g);
      check(g == e, "R2 R3 R4 frame bits", g, e);
      tick();
      check(shift_empty && tx_line, "R8 idle after stop",
            {10'h0, shift_empty, tx_line}, 12'b11);
    end

    // Back-to-back and ignored write: R5 R7
    set_fmt(3'd7, 1'b0, 1'b0, 1'b0);
    write_char(8'hA5);
    g = '0;
    capture(0, 1, g);
    write_char(8'h3C);
    write_char(8'hFF);
    check(!in_ready, "R5 write while full blocked", {11'h0, in_ready}, 12'h0);
    capture(1, 10, g);
    build_frame(3'd7, 1'b0, 1'b0, 1'b0, 8'hA5, e, n);
    check(g == e, "R2 first frame", g, e);
    g = '0;
    capture(0, 1, g);
    check(g[0] == 1'b0 && !shift_empty, "R7 no idle gap",
          {10'h0, g[0], shift_empty}, 12'b00);
    capture(1, 10, g);
    build_frame(3'd7, 1'b0, 1'b0, 1'b0, 8'h3C, e, n);
    check(g == e, "R5 held char kept", g, e);
    tick();

    // Disabled transmitter: R9
    tx_en = 1'b0;
    write_char(8'h81);
    tick(); tick(); tick();
    check(shift_empty && tx_line && !in_ready, "R9 no start while disabled",
          {9'h0, shift_empty, tx_line, in_ready}, 12'b110);
    tx_en = 1'b1;
    g = '0;
    capture(0, 1, g);
    tx_en = 1'b0;
    capture(1, 10, g);
    build_frame(3'd7, 1'b0, 1'b0, 1'b0, 8'h81, e, n);
    check(g == e, "R9 frame completes after disable", g, e);
    tx_en = 1'b1;
    tick();

    // Format change mid-frame: R10
    set_fmt(3'd3, 1'b1, 1'b0, 1'b1);
    build_frame(3'd3, 1'b1, 1'b0, 1'b1, 8'h06, e, n);
    write_char(8'h06);
    g = '0;
    capture(0, 1, g);
    set_fmt(3'd7, 1'b0, 1'b1, 1'b0);
    capture(1, n, g);
    check(g == e, "R10 format captured at load", g, e);
    tick();

    // Line only moves on ticks: R12
    write_char(8'h00);
    repeat (5) @(negedge clk);
    check(tx_line && shift_empty, "R12 no move without tick",
          {10'h0, tx_line, shift_empty}, 12'b11);
    capture(0, 1, g);
    capture(1, 10, g);
    tick();

    // Interrupt mask: R11
    irq_en = 1'b1;
    @(negedge clk);
    check(irq, "R11 irq when ready", {11'h0, irq}, 12'h1);
    tx_en = 1'b0;
    write_char(8'h11);
    check(!irq, "R11 irq low when full", {11'h0, irq}, 12'h0);
    irq_en = 1'b0;
    tx_en = 1'b1;
    capture(0, 10, g);
    tick();
    @(negedge clk);
    check(!irq && in_ready, "R11 irq masked", {10'h0, irq, in_ready}, 12'b01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule